// File: doc/BRIEF.md
# Tree VLIW Multiway Branch Unit

This unit resolves the control flow of a wide instruction word every cycle without any prediction. Each word begins with a 72-bit control header. The header describes a small decision tree of up to three condition tests and four leaves. Each test names one bit of one entry in a 16-entry, 4-bit condition register file. The unit reads those bits through three independent read ports and walks the tree in priority order. It then picks one leaf, which is the taken path.

The chosen leaf supplies two things. The first is a 2-bit slot that steers a 4:1 choice among the four words of an instruction line that was already fetched. The second is an 8-bit mask naming which of the eight operations in the word may commit. The header also carries the address of the line that holds all four possible successors. The unit hands that address to the fetch stage unchanged. All outputs are registered at the stage boundary, one clock after the header and condition file are presented.

Top module: `tvbu_branch_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, every output is cleared to zero at that edge.
- R2: Test k occupies header bits [7k+6:7k]. Bits [7k+3:7k] are a condition register index, [7k+5:7k+4] select a bit within the entry, and [7k+6] is a polarity. A valid test fires when the selected condition bit equals its polarity.
- R3: Leaves are chosen by priority. Leaf 0 is taken if test 0 fires, else leaf 1 if test 1 fires, else leaf 2 if test 2 fires. Otherwise leaf 3 is taken, and `path_o` reports the leaf index.
- R4: Header bit 21+k is the valid bit of test k. A test whose valid bit is 0 counts as firing, so the tree resolves to the earlier leaf.
- R5: Leaf p occupies header bits [24+10p+9:24+10p]. Its low 2 bits drive `tgt_sel_o` and its upper 8 bits drive `op_mask_o`. Both outputs come from the taken leaf, one clock after the header is presented.
- R6: Header bits [71:64] appear on `next_line_o` one clock later, whatever the tree outcome.
- R7: The three tests read the condition file independently, and any of them may name the same entry. Entry e, bit b is `cr_file_i[4e+b]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_i | input | 72 | Control header of the word in the execute stage |
| cr_file_i | input | 64 | Condition register file contents, 16 entries of 4 bits |
| path_o | output | 2 | Registered index of the taken leaf |
| tgt_sel_o | output | 2 | Registered select among the four words of the fetched line |
| op_mask_o | output | 8 | Registered commit mask for the eight operations |
| next_line_o | output | 8 | Registered next-line fetch address |

## Verification
Suppose the unit reads a wrong condition bit, misorders the tests or mishandles a valid bit. That error shows up on `path_o` in the very next cycle, and the slot and mask then come from the wrong leaf as well. A wrong field offset shows up on `tgt_sel_o`, `op_mask_o` or `next_line_o` one clock after a header that exercises it. The sweep covers every combination of valid bits and fired tests, including tests that share one entry. Pseudo-random headers and condition files then cover the index, bit-select and polarity fields.

// File: rtl/tvbu_pkg.sv
package tvbu_pkg;
    localparam int CR_ENTRIES = 16;
    localparam int CR_BITS    = 4;
    localparam int N_TESTS    = 3;
    localparam int N_LEAVES   = N_TESTS + 1;
    localparam int N_OPS      = 8;
    localparam int HDR_W      = 72;

    localparam int CR_IDX_W   = $clog2(CR_ENTRIES);
    localparam int BSEL_W     = $clog2(CR_BITS);
    localparam int PATH_W     = $clog2(N_LEAVES);
    localparam int SLOT_W     = 2;
    localparam int TEST_W     = CR_IDX_W + BSEL_W + 1;
    localparam int LEAF_W     = SLOT_W + N_OPS;
    localparam int VALID_LSB  = N_TESTS * TEST_W;
    localparam int LEAF_LSB   = VALID_LSB + N_TESTS;
    localparam int NLA_LSB    = LEAF_LSB + N_LEAVES * LEAF_W;
    localparam int NLA_W      = HDR_W - NLA_LSB;
    localparam int CR_W       = CR_ENTRIES * CR_BITS;

    typedef struct packed {
        logic                pol;
        logic [BSEL_W-1:0]   bsel;
        logic [CR_IDX_W-1:0] idx;
    } test_t;

    typedef struct packed {
        logic [N_OPS-1:0]  mask;
        logic [SLOT_W-1:0] slot;
    } leaf_t;

    typedef struct packed {
        logic [NLA_W-1:0]             nla;
        leaf_t [N_LEAVES-1:0]         leaves;
        logic [N_TESTS-1:0]           valid;
        test_t [N_TESTS-1:0]          tests;
    } hdr_t;

    typedef struct packed {
        logic [PATH_W-1:0] path;
        logic [SLOT_W-1:0] slot;
        logic [N_OPS-1:0]  mask;
        logic [NLA_W-1:0]  nla;
    } bu_out_t;

    function automatic leaf_t leaf_of(input logic [HDR_W-1:0] raw,
                                      input logic [PATH_W-1:0] p);
        hdr_t h;
        h = hdr_t'(raw);
        return h.leaves[p];
    endfunction
endpackage

// File: rtl/tvbu_cr_port.sv
module tvbu_cr_port
    import tvbu_pkg::*;
#(
    parameter int ENTRIES = CR_ENTRIES,
    parameter int BITS    = CR_BITS
) (
    input  logic [ENTRIES*BITS-1:0]     cr_file,
    input  logic [$clog2(ENTRIES)-1:0]  idx,
    input  logic [$clog2(BITS)-1:0]     bsel,
    output logic                        bit_o
);
    // Entries are power-of-two wide, so the flat position is {idx, bsel}.
    localparam int POS_W = $clog2(ENTRIES) + $clog2(BITS);
    logic [POS_W-1:0] pos;

    always_comb begin
        pos   = {idx, bsel};
        bit_o = cr_file[pos];
    end
endmodule

// File: rtl/tvbu_tree_eval.sv
module tvbu_tree_eval
    import tvbu_pkg::*;
#(
    parameter int TESTS = N_TESTS
) (
    input  logic [TESTS-1:0]           fire,
    output logic [$clog2(TESTS+1)-1:0] path
);
    localparam int PW = $clog2(TESTS + 1);

    // Lowest firing test wins; none firing falls through to the last leaf.
    always_comb begin
        path = PW'(TESTS);
        for (int k = TESTS - 1; k >= 0; k--) begin
            if (fire[k]) path = PW'(k);
        end
    end
endmodule

// File: rtl/tvbu_branch_unit.sv
module tvbu_branch_unit
    import tvbu_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [HDR_W-1:0] hdr_i,
    input  logic [CR_W-1:0]  cr_file_i,
    output logic [PATH_W-1:0] path_o,
    output logic [SLOT_W-1:0] tgt_sel_o,
    output logic [N_OPS-1:0]  op_mask_o,
    output logic [NLA_W-1:0]  next_line_o
);
    hdr_t               hdr;
    logic [N_TESTS-1:0] cond_bit;
    logic [N_TESTS-1:0] fire;
    logic [PATH_W-1:0]  path_d;
    leaf_t              leaf_d;
    bu_out_t            out_d;
    bu_out_t            out_q;

    assign hdr = hdr_t'(hdr_i);

    for (genvar k = 0; k < N_TESTS; k++) begin : g_test
        tvbu_cr_port #(.ENTRIES(CR_ENTRIES), .BITS(CR_BITS)) u_port (
            .cr_file (cr_file_i),
            .idx     (hdr.tests[k].idx),
            .bsel    (hdr.tests[k].bsel),
            .bit_o   (cond_bit[k])
        );
        assign fire[k] = !hdr.valid[k] || (cond_bit[k] == hdr.tests[k].pol);
    end

    tvbu_tree_eval #(.TESTS(N_TESTS)) u_tree (
        .fire (fire),
        .path (path_d)
    );

    always_comb begin
        leaf_d     = hdr.leaves[path_d];
        out_d.path = path_d;
        out_d.slot = leaf_d.slot;
        out_d.mask = leaf_d.mask;
        out_d.nla  = hdr.nla;
    end

    always_ff @(posedge clk) begin
        if (rst) out_q <= '0;
        else     out_q <= out_d;
    end

    assign path_o      = out_q.path;
    assign tgt_sel_o   = out_q.slot;
    assign op_mask_o   = out_q.mask;
    assign next_line_o = out_q.nla;

    // R5: slot and mask belong to the leaf reported on path_o
    a_r5_leaf_fields: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (op_mask_o == leaf_of($past(hdr_i), path_o).mask) &&
                 (tgt_sel_o == leaf_of($past(hdr_i), path_o).slot));

    // R6: next-line address is forwarded untouched
    a_r6_next_line: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> next_line_o == $past(hdr_i[HDR_W-1:NLA_LSB]));

    // R3: first test firing forces leaf 0
    a_r3_first_wins: assert property (@(posedge clk) disable iff (rst)
        fire[0] |=> path_o == '0);

    // R4: an unused first test resolves to leaf 0
    a_r4_unused_early: assert property (@(posedge clk) disable iff (rst)
        !hdr_i[VALID_LSB] |=> path_o == '0);

    // R3: no test firing selects the final leaf
    a_r3_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (fire == '0) |=> path_o == PATH_W'(N_TESTS));
endmodule

// File: tb/test_tvbu_branch_unit.sv
module test_tvbu_branch_unit;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [71:0] hdr_i = '0;
    logic [63:0] cr_file_i = '0;
    logic [1:0]  path_o;
    logic [1:0]  tgt_sel_o;
    logic [7:0]  op_mask_o;
    logic [7:0]  next_line_o;

    int checks = 0;
    int failures = 0;

    tvbu_branch_unit i_tvbu_branch_unit (
        .clk(clk), .rst(rst), .hdr_i(hdr_i), .cr_file_i(cr_file_i),
        .path_o(path_o), .tgt_sel_o(tgt_sel_o),
        .op_mask_o(op_mask_o), .next_line_o(next_line_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int model_path(input logic [71:0] h, input logic [63:0] cr);
        for (int k = 0; k < 3; k++) begin
            int idx = int'(h[7*k +: 4]);
            int b   = int'(h[7*k+4 +: 2]);
            logic pol = h[7*k+6];
            logic v   = h[21+k];
            if (!v || cr[idx*4+b] == pol) return k;
        end
        return 3;
    endfunction

    // Present one header; check outputs just after the capturing edge.
    task automatic apply(input string req, input logic [71:0] h, input logic [63:0] cr);
        int p;
        hdr_i = h;
        cr_file_i = cr;
        p = model_path(h, cr);
        @(posedge clk);
        #1;
        chk(req, "path", int'(path_o), p);
        chk("R5", "slot", int'(tgt_sel_o), int'(h[24+10*p +: 2]));
        chk("R5", "mask", int'(op_mask_o), int'(h[26+10*p +: 8]));
        chk("R6", "next_line", int'(next_line_o), int'(h[71:64]));
    endtask

    function automatic logic [71:0] leaves_fill(input logic [7:0] nla);
        logic [71:0] h = '0;
        for (int p = 0; p < 4; p++) begin
            h[24+10*p +: 2] = 2'(3 - p);
            h[26+10*p +: 8] = 8'(8'h11 << p) ^ 8'(p * 37);
        end
        h[71:64] = nla;
        return h;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] s1;
        logic [63:0] s2;
        logic [71:0] h;

        // R1: outputs held at zero during reset despite active inputs
        hdr_i = {8'hA5, 64'hFFFF_FFFF_FFFF_FFFF};
        cr_file_i = 64'h1234_5678_9ABC_DEF0;
        repeat (3) @(posedge clk);
        #1;
        chk("R1", "path", int'(path_o), 0);
        chk("R1", "slot", int'(tgt_sel_o), 0);
        chk("R1", "mask", int'(op_mask_o), 0);
        chk("R1", "next_line", int'(next_line_o), 0);
        rst = 1'b0;

        // R3: example tree A(pol 0), B(pol 1), C(pol 0) on entries 1,6,12
        for (int abc = 0; abc < 8; abc++) begin
            logic [63:0] cr = '0;
            h = leaves_fill(8'(8'h40 + abc));
            h[6:0]   = {1'b0, 2'd2, 4'd1};
            h[13:7]  = {1'b1, 2'd0, 4'd6};
            h[20:14] = {1'b0, 2'd3, 4'd12};
            h[23:21] = 3'b111;
            cr[1*4+2]  = abc[0];
            cr[6*4+0]  = abc[1];
            cr[12*4+3] = abc[2];
            apply("R3", h, cr);
            chk("R3", "example_leaf", int'(path_o),
                !abc[0] ? 0 : abc[1] ? 1 : !abc[2] ? 2 : 3);
        end

        // R4 and R2: every valid pattern against every fired pattern
        for (int v = 0; v < 8; v++) begin
            for (int c = 0; c < 8; c++) begin
                logic [63:0] cr = 64'hFFFF_FFFF_FFFF_FFFF;
                h = leaves_fill(8'(v * 8 + c));
                h[6:0]   = {1'b1, 2'd3, 4'd2};
                h[13:7]  = {1'b0, 2'd0, 4'd9};
                h[20:14] = {1'b1, 2'd2, 4'd15};
                h[23:21] = 3'(v);
                cr[2*4+3]  = c[0];
                cr[9*4+0]  = ~c[1];
                cr[15*4+2] = c[2];
                apply("R4", h, cr);
            end
        end

        // R7: all three tests read one shared entry, different bits
        for (int e = 0; e < 16; e++) begin
            for (int val = 0; val < 16; val++) begin
                logic [63:0] cr = ~64'h0;
                h = leaves_fill(8'(e * 16 + val));
                h[6:0]   = {1'b0, 2'd0, 4'(e)};
                h[13:7]  = {1'b0, 2'd1, 4'(e)};
                h[20:14] = {1'b1, 2'd3, 4'(e)};
                h[23:21] = 3'b111;
                cr[e*4 +: 4] = 4'(val);
                apply("R7", h, cr);
            end
        end

        // R2: pseudo-random headers and condition files
        s1 = 64'h9E37_79B9_7F4A_7C15;
        s2 = 64'hC2B2_AE3D_27D4_EB4F;
        for (int n = 0; n < 3000; n++) begin
            s1 = s1 ^ (s1 << 13); s1 = s1 ^ (s1 >> 7); s1 = s1 ^ (s1 << 17);
            s2 = s2 ^ (s2 << 13); s2 = s2 ^ (s2 >> 7); s2 = s2 ^ (s2 << 17);
            h = {s2[63:56], s1};
            if (n % 4 == 0) h[23:21] = 3'b111;
            apply("R2", h, s2 ^ {s1[31:0], s1[63:32]});
        end

        // R1: reset asserted mid-stream clears outputs again
        rst = 1'b1;
        @(posedge clk);
        #1;
        chk("R1", "path_after_rerst", int'(path_o), 0);
        chk("R1", "mask_after_rerst", int'(op_mask_o), 0);
        chk("R1", "next_line_after_rerst", int'(next_line_o), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule